// File: doc/BRIEF.md
# Hardware Cursor Overlay Engine

This block draws a 64x64 pixel cursor over a raster stream. Each clock it takes the current raster coordinate and the incoming pixel colour. It returns either that colour unchanged or one of two programmed cursor colours. The output is registered, so it lags the inputs by one clock. The cursor image is held in two bit planes. The pair of bits for a pixel selects transparent, background or foreground.

Software reaches every setting through an indirect register port. A write to the address port loads an internal pointer. Each following data read or data write acts on the register that pointer selects, then moves the pointer on by one. A whole cursor image, or both colours, can therefore be streamed after a single address write.

The cursor origin is a signed coordinate, so the image can hang off the left or top edge of the screen. A strap input flips the sense of the two control bits, so the same software runs on parts with either polarity.

Top module: `cursor_overlay`

## Requirements
- R1: Address 0x000 holds the origin. X sits in the low half: sign in bit 15 and a 12-bit coordinate in bits 11:0. Y sits in the high half: sign in bit 31 and coordinate in bits 27:16. Each half is a 13-bit two's-complement value. Write bits 14:12 and 30:28 are dropped and read back as 0.
- R2: Address 0x002 holds the background colour and 0x003 the foreground colour. After the pointer is set to 0x002, two data writes load background first and then foreground. Colours are 24 bits wide; bits 31:24 are dropped and read back as 0.
- R3: Address 0x001 bits 1:0 are the control pair; reset value 2'b11. With `inv_ctl` low, the cursor is enabled only when both bits are 0. Any other value disables it, and `pix_out` then repeats `pix_in`.
- R4: With `inv_ctl` high, the sense is inverted: the cursor is enabled only when both control bits are 1.
- R5: Plane 0 occupies 0x100..0x17F and plane 1 follows at 0x180..0x1FF. Row r of a plane is the word at base+2r (left half) and base+2r+1 (right half). Every word reads back as written.
- R6: An address-port write sets the pointer. Each data read or data write then advances it by one, wrapping from 0x1FF to 0x000; a cycle with both strobes counts once as a write. A data strobe in the same cycle as an address write is ignored.
- R7: For raster (x,y) and origin (X,Y), let dx=x-X and dy=y-Y. The pixel is covered only when 0<=dx<=63 and 0<=dy<=63. It uses bit 31-(dx mod 32) of the row's word dx/32, so bit 31 of the left word is the leftmost pixel. Raster coordinates are unsigned 12-bit values, so negative positions are never drawn.
- R8: For a covered pixel on an enabled cursor, the code is {plane-1 bit, plane-0 bit}. Code 01 outputs the background colour and 10 the foreground colour. Codes 00 and 11 pass `pix_in` through.
- R9: `pix_out` is registered: it reflects the pixel inputs and settings of the previous clock. When the cursor is disabled or the pixel is uncovered, it equals the previous `pix_in`.
- R10: On reset every register and bitmap word is 0, except the control pair (2'b11). A data read updates `reg_rdata` on the next clock with the word at the pointer. Unmapped addresses 0x004..0x0FF read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_ctl | input | 1 | Strap that inverts the control pair sense |
| reg_addr_we | input | 1 | Address port write strobe |
| reg_addr | input | 9 | Value loaded into the register pointer |
| reg_data_we | input | 1 | Data port write strobe |
| reg_data_re | input | 1 | Data port read strobe |
| reg_wdata | input | 32 | Data port write value |
| reg_rdata | output | 32 | Data port read value, valid the clock after a read |
| pix_x | input | 12 | Raster column |
| pix_y | input | 12 | Raster row |
| pix_in | input | 24 | Incoming pixel colour |
| pix_out | output | 24 | Pixel colour with cursor applied |

## Verification
The checker watches the pointer on every clock: it loads on address writes, steps once per data access and holds otherwise. On every clock it also checks that the output is a plain one-clock delay of the input whenever the cursor is off or the pixel is uncovered. It further checks that the two colour codes produce the stored colours, and that masked and unmapped reads return zeros. Only the bench scenarios can show that the image lands at the right place. This covers bit order within a word, the split between left and right words, plane 1 following plane 0, and origins below zero. The same holds for the background-first colour order, the address wrap, and the strap inverting the control pair, which the bench shows by comparing pixels against its own model.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
   localparam int unsigned CUR_DIM       = 64;
   localparam int unsigned WORD_W        = 32;
   localparam int unsigned REG_AW        = 9;
   localparam int unsigned PLANES        = 2;
   localparam int unsigned WORDS_PER_ROW = CUR_DIM / WORD_W;
   localparam int unsigned PLANE_WORDS   = CUR_DIM * WORDS_PER_ROW;
   localparam int unsigned PIDX_W        = $clog2(PLANE_WORDS);
   localparam int unsigned DIM_W         = $clog2(CUR_DIM);
   localparam int unsigned BIT_W         = $clog2(WORD_W);

   localparam logic [REG_AW-1:0] A_ORIGIN = 9'h000;
   localparam logic [REG_AW-1:0] A_CTRL   = 9'h001;
   localparam logic [REG_AW-1:0] A_COL_BG = 9'h002;
   localparam logic [REG_AW-1:0] A_COL_FG = 9'h003;

   typedef enum logic [1:0] {
      PX_CLEAR = 2'b00,
      PX_BG    = 2'b01,
      PX_FG    = 2'b10,
      PX_HOLE  = 2'b11
   } pix_code_e;
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
   import cursor_pkg::*;
#(
   parameter int COORD_W = 12,
   parameter int COLOR_W = 24
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              addr_we,
   input  logic [REG_AW-1:0]                 addr_in,
   input  logic                              data_we,
   input  logic                              data_re,
   input  logic [WORD_W-1:0]                 wdata,
   output logic [WORD_W-1:0]                 rdata,
   output logic [REG_AW-1:0]                 ptr_o,
   output logic [COORD_W:0]                  org_x_o,
   output logic [COORD_W:0]                  org_y_o,
   output logic [1:0]                        ctrl_o,
   output logic [COLOR_W-1:0]                bg_o,
   output logic [COLOR_W-1:0]                fg_o,
   input  logic [PIDX_W-1:0]                 bm_idx,
   output logic [PLANES-1:0][WORD_W-1:0]     bm_word
);
   localparam logic [15:0] HALF_MASK = 16'h8000 | 16'((1 << COORD_W) - 1);
   localparam logic [31:0] ORG_MASK  = {HALF_MASK, HALF_MASK};

   logic [REG_AW-1:0]             ptr_q;
   logic [WORD_W-1:0]             org_q;
   logic [1:0]                    ctrl_q;
   logic [COLOR_W-1:0]            bg_q, fg_q;
   logic [WORD_W-1:0]             rd_val;
   logic [PLANES-1:0][WORD_W-1:0] bm_rd;
   logic                          wr_go, rd_go, step, in_bm;

   assign wr_go = data_we & ~addr_we;
   assign rd_go = data_re & ~data_we & ~addr_we;
   assign step  = (data_we | data_re) & ~addr_we;
   assign in_bm = ptr_q[REG_AW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr_q <= '0;
      else if (addr_we) ptr_q <= addr_in;
      else if (step)    ptr_q <= ptr_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         org_q  <= '0;
         ctrl_q <= 2'b11;
         bg_q   <= '0;
         fg_q   <= '0;
      end else if (wr_go && !in_bm) begin
         case (ptr_q)
            A_ORIGIN: org_q  <= wdata & ORG_MASK;
            A_CTRL:   ctrl_q <= wdata[1:0];
            A_COL_BG: bg_q   <= wdata[COLOR_W-1:0];
            A_COL_FG: fg_q   <= wdata[COLOR_W-1:0];
            default:  ;
         endcase
      end
   end

   for (genvar p = 0; p < PLANES; p++) begin : g_plane
      logic [WORD_W-1:0] mem_q [PLANE_WORDS];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < PLANE_WORDS; i++) mem_q[i] <= '0;
         end else if (wr_go && in_bm && (ptr_q[PIDX_W] == 1'(p))) begin
            mem_q[ptr_q[PIDX_W-1:0]] <= wdata;
         end
      end
      assign bm_word[p] = mem_q[bm_idx];
      assign bm_rd[p]   = mem_q[ptr_q[PIDX_W-1:0]];
   end

   always_comb begin
      rd_val = '0;
      if (in_bm) begin
         rd_val = bm_rd[ptr_q[PIDX_W]];
      end else begin
         case (ptr_q)
            A_ORIGIN: rd_val = org_q;
            A_CTRL:   rd_val = {30'b0, ctrl_q};
            A_COL_BG: rd_val = WORD_W'(bg_q);
            A_COL_FG: rd_val = WORD_W'(fg_q);
            default:  rd_val = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_go) rdata <= rd_val;
   end

   assign ptr_o   = ptr_q;
   assign org_x_o = {org_q[15], org_q[COORD_W-1:0]};
   assign org_y_o = {org_q[31], org_q[16+COORD_W-1:16]};
   assign ctrl_o  = ctrl_q;
   assign bg_o    = bg_q;
   assign fg_o    = fg_q;
endmodule

// File: rtl/cursor_window.sv
module cursor_window
   import cursor_pkg::*;
#(
   parameter int COORD_W = 12
) (
   input  logic [COORD_W-1:0] pix_x,
   input  logic [COORD_W-1:0] pix_y,
   input  logic [COORD_W:0]   org_x,
   input  logic [COORD_W:0]   org_y,
   output logic               hit,
   output logic [PIDX_W-1:0]  word_idx,
   output logic [BIT_W-1:0]   bit_sel
);
   localparam int DW = COORD_W + 2;

   logic signed [DW-1:0] dx, dy;

   assign dx = $signed({2'b00, pix_x}) - $signed({org_x[COORD_W], org_x});
   assign dy = $signed({2'b00, pix_y}) - $signed({org_y[COORD_W], org_y});

   assign hit      = (dx[DW-1:DIM_W] == '0) && (dy[DW-1:DIM_W] == '0);
   assign word_idx = {dy[DIM_W-1:0], dx[DIM_W-1:BIT_W]};
   assign bit_sel  = BIT_W'(WORD_W - 1) - dx[BIT_W-1:0];
endmodule

// File: rtl/cursor_mix.sv
module cursor_mix
   import cursor_pkg::*;
#(
   parameter int COLOR_W = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               hit,
   input  pix_code_e          code,
   input  logic [COLOR_W-1:0] bg,
   input  logic [COLOR_W-1:0] fg,
   input  logic [COLOR_W-1:0] pix_in,
   output logic [COLOR_W-1:0] pix_out
);
   logic [COLOR_W-1:0] sel;

   always_comb begin
      sel = pix_in;
      if (en && hit) begin
         case (code)
            PX_BG:   sel = bg;
            PX_FG:   sel = fg;
            default: sel = pix_in;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pix_out <= '0;
      else        pix_out <= sel;
   end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
   import cursor_pkg::*;
#(
   parameter int COORD_W = 12,
   parameter int COLOR_W = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               inv_ctl,
   input  logic               reg_addr_we,
   input  logic [REG_AW-1:0]  reg_addr,
   input  logic               reg_data_we,
   input  logic               reg_data_re,
   input  logic [WORD_W-1:0]  reg_wdata,
   output logic [WORD_W-1:0]  reg_rdata,
   input  logic [COORD_W-1:0] pix_x,
   input  logic [COORD_W-1:0] pix_y,
   input  logic [COLOR_W-1:0] pix_in,
   output logic [COLOR_W-1:0] pix_out
);
   if (COORD_W < DIM_W + 1 || COORD_W > 15) begin : g_bad_coord
      $error("cursor_overlay: COORD_W must lie in 7..15");
   end
   if (COLOR_W < 1 || COLOR_W > WORD_W) begin : g_bad_color
      $error("cursor_overlay: COLOR_W must lie in 1..32");
   end

   logic [REG_AW-1:0]             ptr_w;
   logic [COORD_W:0]              org_x_w, org_y_w;
   logic [1:0]                    ctrl_w;
   logic [COLOR_W-1:0]            bg_w, fg_w;
   logic [PIDX_W-1:0]             idx_w;
   logic [BIT_W-1:0]              bit_w;
   logic [PLANES-1:0][WORD_W-1:0] bm_w;
   logic [PLANES-1:0]             code_w;
   logic                          hit_w, cur_en;

   cursor_regs #(.COORD_W(COORD_W), .COLOR_W(COLOR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .addr_we(reg_addr_we), .addr_in(reg_addr),
      .data_we(reg_data_we), .data_re(reg_data_re),
      .wdata(reg_wdata), .rdata(reg_rdata),
      .ptr_o(ptr_w), .org_x_o(org_x_w), .org_y_o(org_y_w),
      .ctrl_o(ctrl_w), .bg_o(bg_w), .fg_o(fg_w),
      .bm_idx(idx_w), .bm_word(bm_w)
   );

   cursor_window #(.COORD_W(COORD_W)) u_win (
      .pix_x(pix_x), .pix_y(pix_y),
      .org_x(org_x_w), .org_y(org_y_w),
      .hit(hit_w), .word_idx(idx_w), .bit_sel(bit_w)
   );

   for (genvar p = 0; p < PLANES; p++) begin : g_code
      assign code_w[p] = bm_w[p][bit_w];
   end

   assign cur_en = ((ctrl_w ^ {2{inv_ctl}}) == 2'b00);

   cursor_mix #(.COLOR_W(COLOR_W)) u_mix (
      .clk(clk), .rst_n(rst_n),
      .en(cur_en), .hit(hit_w), .code(pix_code_e'(code_w)),
      .bg(bg_w), .fg(fg_w),
      .pix_in(pix_in), .pix_out(pix_out)
   );
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk
   import cursor_pkg::*;
#(
   parameter int COORD_W = 12,
   parameter int COLOR_W = 24
) (
   input logic               clk,
   input logic               rst_n,
   input logic               addr_we,
   input logic [REG_AW-1:0]  addr_in,
   input logic               data_we,
   input logic               data_re,
   input logic [WORD_W-1:0]  rdata,
   input logic [REG_AW-1:0]  ptr,
   input logic               cur_en,
   input logic               hit,
   input logic [1:0]         code,
   input logic [COLOR_W-1:0] bg,
   input logic [COLOR_W-1:0] fg,
   input logic [COLOR_W-1:0] pix_in,
   input logic [COLOR_W-1:0] pix_out
);
   localparam logic [15:0] HALF_KEEP = 16'h8000 | 16'((1 << COORD_W) - 1);
   localparam logic [31:0] ORG_KEEP  = {HALF_KEEP, HALF_KEEP};

   logic plain_rd;
   assign plain_rd = data_re && !data_we && !addr_we;

   a_r6_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
      addr_we |=> ptr == $past(addr_in));

   a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_we && (data_we || data_re)) |=> ptr == REG_AW'($past(ptr) + 1'b1));

   a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_we && !data_we && !data_re) |=> $stable(ptr));

   a_r9_pass_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !cur_en |=> pix_out == $past(pix_in));

   a_r9_pass_uncovered: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> pix_out == $past(pix_in));

   a_r8_fg_code: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_en && hit && code == 2'b10) |=> pix_out == $past(fg));

   a_r8_bg_code: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_en && hit && code == 2'b01) |=> pix_out == $past(bg));

   a_r1_origin_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (plain_rd && ptr == A_ORIGIN) |=> (rdata & ~ORG_KEEP) == '0);

   a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (plain_rd && !ptr[REG_AW-1] && ptr > A_COL_FG) |=> rdata == '0);
endmodule

bind cursor_overlay cursor_overlay_chk #(.COORD_W(COORD_W), .COLOR_W(COLOR_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .addr_we(reg_addr_we), .addr_in(reg_addr),
   .data_we(reg_data_we), .data_re(reg_data_re),
   .rdata(reg_rdata), .ptr(ptr_w),
   .cur_en(cur_en), .hit(hit_w), .code(code_w),
   .bg(bg_w), .fg(fg_w),
   .pix_in(pix_in), .pix_out(pix_out)
);

// File: tb/tb_cursor_overlay.sv
`timescale 1ns/1ps
module tb_cursor_overlay;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        inv_ctl;
   logic        reg_addr_we;
   logic [8:0]  reg_addr;
   logic        reg_data_we;
   logic        reg_data_re;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic [11:0] pix_x, pix_y;
   logic [23:0] pix_in;
   logic [23:0] pix_out;

   int n_chk  = 0;
   int n_fail = 0;

   logic [31:0] sh_org;
   logic [1:0]  sh_ctrl;
   logic [23:0] sh_bg, sh_fg;
   logic [31:0] sh_bm [256];

   always #5 clk = ~clk;

   cursor_overlay dut (
      .clk(clk), .rst_n(rst_n), .inv_ctl(inv_ctl),
      .reg_addr_we(reg_addr_we), .reg_addr(reg_addr),
      .reg_data_we(reg_data_we), .reg_data_re(reg_data_re),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pix_x(pix_x), .pix_y(pix_y), .pix_in(pix_in), .pix_out(pix_out)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int to_signed13(input logic sgn, input logic [11:0] c);
      return sgn ? int'(c) - 4096 : int'(c);
   endfunction

   function automatic logic [23:0] model_pix(input int x, input int y, input logic [23:0] pin);
      int ox, oy, dx, dy, wi, b;
      logic p0, p1;
      if ((sh_ctrl ^ {inv_ctl, inv_ctl}) != 2'b00) return pin;
      ox = to_signed13(sh_org[15], sh_org[11:0]);
      oy = to_signed13(sh_org[31], sh_org[27:16]);
      dx = x - ox;
      dy = y - oy;
      if (dx < 0 || dx > 63 || dy < 0 || dy > 63) return pin;
      wi = dy * 2 + dx / 32;
      b  = 31 - (dx % 32);
      p0 = sh_bm[wi][b];
      p1 = sh_bm[128 + wi][b];
      case ({p1, p0})
         2'b01:   return sh_bg;
         2'b10:   return sh_fg;
         default: return pin;
      endcase
   endfunction

   // All tasks start and end at a falling edge.
   task automatic t_addr(input logic [8:0] a);
      reg_addr_we = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_addr_we = 1'b0;
   endtask

   task automatic t_wr(input logic [31:0] d);
      reg_data_we = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_data_we = 1'b0;
   endtask

   task automatic t_rd(output logic [31:0] d);
      reg_data_re = 1'b1;
      @(negedge clk);
      reg_data_re = 1'b0;
      d = reg_rdata;
   endtask

   task automatic t_pix(input int x, input int y, input logic [23:0] pin, input string tag);
      logic [23:0] exp;
      pix_x = 12'(x); pix_y = 12'(y); pix_in = pin;
      exp = model_pix(x, y, pin);
      @(negedge clk);
      check(tag, 32'(pix_out), 32'(exp));
   endtask

   task automatic set_org(input logic [31:0] v);
      t_addr(9'h000);
      t_wr(v);
      sh_org = v & 32'h8FFF_8FFF;
   endtask

   task automatic set_ctrl(input logic [1:0] c);
      t_addr(9'h001);
      t_wr({30'h3FFF_FFFF, c});
      sh_ctrl = c;
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired before the test completed");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      int seed;
      seed = $urandom(32'd2024);
      rst_n = 1'b0; inv_ctl = 1'b0;
      reg_addr_we = 0; reg_addr = 0; reg_data_we = 0; reg_data_re = 0; reg_wdata = 0;
      pix_x = 0; pix_y = 0; pix_in = 0;
      sh_org = 0; sh_ctrl = 2'b11; sh_bg = 0; sh_fg = 0;
      for (int i = 0; i < 256; i++) sh_bm[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // Reset state
      t_pix(7, 9, 24'h123456, "R3 reset value disables cursor");
      t_addr(9'h000);
      t_rd(rd); check("R10 origin resets to 0", rd, 32'h0);
      t_rd(rd); check("R10 ctrl resets to 11 (R6 step)", rd, 32'h3);

      // Origin packing and masking
      set_org(32'h7005_FFF6);
      t_addr(9'h000);
      t_rd(rd); check("R1 origin masked readback", rd, 32'h0005_8FF6);

      // Colour order
      t_addr(9'h002);
      t_wr(32'hAB11_2233); t_wr(32'hCD44_5566);
      sh_bg = 24'h112233; sh_fg = 24'h445566;
      t_addr(9'h003);
      t_rd(rd); check("R2 second write is foreground", rd, 32'h0044_5566);
      t_addr(9'h002);
      t_rd(rd); check("R2 first write is background", rd, 32'h0011_2233);

      // Bitmap stream
      t_addr(9'h100);
      for (int i = 0; i < 256; i++) begin
         logic [31:0] w;
         w = $urandom;
         sh_bm[i] = w;
         t_wr(w);
      end
      t_addr(9'h100); t_wr(32'hA000_0000); sh_bm[0]   = 32'hA000_0000;
      t_addr(9'h180); t_wr(32'h6000_0000); sh_bm[128] = 32'h6000_0000;
      t_addr(9'h17F);
      t_rd(rd); check("R5 last plane-0 word", rd, sh_bm[127]);
      t_rd(rd); check("R5 plane 1 follows plane 0", rd, sh_bm[128]);

      // Pointer wrap and strobe collision
      t_addr(9'h1FF);
      t_rd(rd); check("R6 top bitmap word", rd, sh_bm[255]);
      t_rd(rd); check("R6 pointer wraps to origin", rd, sh_org);
      reg_addr_we = 1; reg_addr = 9'h002; reg_data_we = 1; reg_wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      reg_addr_we = 0; reg_data_we = 0;
      t_rd(rd); check("R6 data write with address write ignored", rd, 32'(sh_bg));

      // Unmapped address
      t_addr(9'h020); t_wr(32'hDEAD_BEEF);
      t_addr(9'h020);
      t_rd(rd); check("R10 unmapped reads zero", rd, 32'h0);

      // Enable and directed corners, origin (3,5)
      set_ctrl(2'b00);
      set_org(32'h0005_0003);
      t_pix(3, 5, 24'h010101, "R8 code 01 gives background");
      t_pix(4, 5, 24'h020202, "R8 code 10 gives foreground");
      t_pix(5, 5, 24'h030303, "R8 code 11 transparent");
      t_pix(6, 5, 24'h040404, "R8 code 00 transparent");
      t_pix(2, 5, 24'h050505, "R7 left of origin");
      t_pix(66, 5, 24'h060606, "R7 dx 63 column");
      t_pix(67, 5, 24'h070707, "R7 dx 64 uncovered");
      t_pix(35, 40, 24'h080808, "R7 right word bit 31");
      t_pix(3, 68, 24'h090909, "R7 dy 63 row");
      t_pix(3, 69, 24'h0A0A0A, "R7 dy 64 uncovered");
      for (int i = 0; i < 400; i++)
         t_pix($urandom_range(80), $urandom_range(80), 24'($urandom), "R7 random window R9");

      // Negative origin (-10,-3)
      set_org(32'h8FFD_8FF6);
      t_addr(9'h000);
      t_rd(rd); check("R1 negative origin readback", rd, 32'h8FFD_8FF6);
      t_pix(53, 60, 24'h0B0B0B, "R7 negative origin far corner");
      t_pix(54, 0, 24'h0C0C0C, "R7 negative origin past right edge");
      for (int i = 0; i < 300; i++)
         t_pix($urandom_range(70), $urandom_range(70), 24'($urandom), "R7 random negative origin");

      // Control sense
      set_org(32'h0005_0003);
      set_ctrl(2'b01);
      t_pix(3, 5, 24'h0D0D0D, "R3 mixed control 01 disables");
      set_ctrl(2'b11);
      t_pix(4, 5, 24'h0E0E0E, "R3 control 11 disables");
      inv_ctl = 1'b1;
      t_pix(3, 5, 24'h0F0F0F, "R4 inverted, 11 enables");
      set_ctrl(2'b00);
      t_pix(4, 5, 24'h101010, "R4 inverted, 00 disables");
      set_ctrl(2'b11);
      for (int i = 0; i < 100; i++)
         t_pix($urandom_range(80), $urandom_range(80), 24'($urandom), "R4 random inverted");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule